// File: doc/BRIEF.md
# PHY PLL Bring-Up Sequencer

This block powers up a serial display PHY without software help. A single start pulse makes it issue a short clear pulse on the PHY test-control line. It then steps through a fixed list of 24 configuration writes. Each write goes out as an address/data pair to a test-port bridge, and the block waits for the bridge to acknowledge it before sending the next one. Some of the data bytes are computed from the lane rate, the PLL input divider and the PLL feedback divider. All three are captured at the start pulse.

After the last write, the four PHY control lines are raised together: force-PLL, clock enable, reset release and shutdown release. The sequencer then waits for PLL lock and after that for the clock lane to reach its stop state. Each wait has a timeout counted in microsecond ticks. A missing lock is fatal and ends the run with an error. A missing stop state only raises a warning. The done, error and warning flags hold their values until the next start.

Top module: `phy_pll_bringup`

## Requirements
- R1: After a start pulse, the clear output is high for exactly one clock cycle. It is low before and after that cycle, and it is low again before the first write request of the run.
- R2: Write requests carry these addresses, in this order: 0x10, 0x11, 0x12, 0x44, 0x17, 0x18, 0x18, 0x19, 0x22, 0x22, 0x20, 0x21, 0x21, 0x60, 0x61, 0x62, 0x63, 0x64, 0x65, 0x70, 0x71, 0x72, 0x73, 0x74.
- R3: The fixed data bytes are, in order of the list: 0xB0 (0x10), 0x06 (0x11), 0xC8 (0x12), 0x30 (0x19), 0x03 then 0x84 (0x22), 0x4D (0x20), 0x39 then 0xF4 (0x21). Address 0x44 carries ((lane_mbps / 16) mod 128) × 2. Address 0x17 carries the input divider minus one, mod 256. The first write to 0x18 carries feedback bits [4:0]. The second write to 0x18 carries 0x80 OR feedback bits [9:5].
- R4: Define ui(t) = ceil(t × lane_mbps / 1000) and bc(t) = ceil(t × lane_mbps / 8000), both mod 256. The timing bytes, each mod 256, are:
  - 0x60 and 0x70: 0x80|bc(500)
  - 0x61: 0x80|ui(40)
  - 0x62: 0x40|bc(300)
  - 0x63: 0x80|ui(100)
  - 0x64 and 0x74: 0x20|bc(100)
  - 0x65: 0x20|(bc(60)+7)
  - 0x71: 0x80|(ui(50)+5)
  - 0x72: 0x40|(bc(140)+2)
  - 0x73: 0x80|(ui(60)+8)
- R5: Only one request is outstanding at a time. The request line, address and data stay steady until the bridge acknowledges, and the next request starts only after that acknowledge.
- R6: The four PHY control outputs are low from a start pulse until the last write is acknowledged. They then rise in the same cycle and are never seen partly set.
- R7: If lock has not arrived after TIMEOUT_US microsecond ticks, the sequencer sets error and done and does not wait for the stop state.
- R8: If the stop state has not arrived after TIMEOUT_US ticks following lock, the sequencer sets warning and done, and error stays low.
- R9: When lock and stop state both arrive in time, done is set with error and warning low. The control outputs stay high after the run ends.
- R10: A start pulse during a run is ignored. Changes to the rate and divider inputs during a run have no effect on the data written.
- R11: After reset every output is low.
- R12: Busy is high from the cycle after an accepted start until the run ends, and busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| lane_mbps_i | input | RATE_W | Lane rate in Mbit/s |
| in_div_i | input | DIV_W | PLL input divider |
| fb_div_i | input | FB_W | PLL feedback divider |
| us_tick_i | input | 1 | One pulse per microsecond |
| pll_lock_i | input | 1 | PLL lock status |
| clk_stop_i | input | 1 | Clock lane stop-state status |
| wr_done_i | input | 1 | Bridge acknowledge for the current write |
| clr_pulse_o | output | 1 | PHY test-control clear |
| wr_req_o | output | 1 | Write request to the bridge |
| wr_addr_o | output | 8 | Write address |
| wr_data_o | output | 8 | Write data |
| pll_force_o | output | 1 | Force-PLL control |
| clk_en_o | output | 1 | Clock enable control |
| rst_n_o | output | 1 | PHY reset release (active low reset) |
| shutdown_n_o | output | 1 | PHY shutdown release (active low shutdown) |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Sequence finished |
| err_o | output | 1 | Lock timeout |
| warn_o | output | 1 | Stop-state timeout |

## Verification
Two events can land in the same cycle. A bridge acknowledge can coincide with a new start pulse, and a status bit can arrive in the very cycle its timeout expires. The bench drives a start pulse in the middle of the write stream, alongside a changed lane rate and changed dividers. It then judges the result with a scoreboard: the whole write list must match the values captured at the first start, and no second run may follow. The lock and stop-state waits are judged by counting the cycles from the rise of the control outputs to the flag. Tick rates of one per cycle and one per two cycles are both used.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;
  localparam int unsigned N_CFG = 24;
  localparam int unsigned IDX_W = $clog2(N_CFG);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR0, ST_CLR1, ST_CLR2, ST_ISSUE, ST_WAIT,
    ST_PWR, ST_LOCK, ST_STOP
  } seq_state_t;

  // Rate-scaled duration in unit intervals, rounded up
  function automatic logic [7:0] ui_cnt(input int unsigned ns, input int unsigned mbps);
    return 8'((ns * mbps + 32'd999) / 32'd1000);
  endfunction

  // Rate-scaled duration in byte-clock periods, rounded up
  function automatic logic [7:0] bc_cnt(input int unsigned ns, input int unsigned mbps);
    return 8'((ns * mbps + 32'd7999) / 32'd8000);
  endfunction
endpackage

// File: rtl/phy_cfg_table.sv
module phy_cfg_table
  import phy_bringup_pkg::*;
#(
  parameter int RATE_W = 12,
  parameter int DIV_W  = 8,
  parameter int FB_W   = 10
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [DIV_W-1:0]  in_div_i,
  input  logic [FB_W-1:0]   fb_div_i,
  output logic [7:0]        addr_o,
  output logic [7:0]        data_o
);
  localparam int LOW_W = FB_W / 2;

  int unsigned r;
  logic [RATE_W-1:0] rate_sh;
  logic [7:0] fb_lo, fb_hi;

  always_comb begin
    r       = 32'(rate_i);
    rate_sh = rate_i >> 4;
    fb_lo   = 8'(fb_div_i[LOW_W-1:0]);
    fb_hi   = 8'(fb_div_i[FB_W-1:LOW_W]);
    addr_o  = 8'h00;
    data_o  = 8'h00;
    case (idx_i)
      5'd0:  begin addr_o = 8'h10; data_o = 8'hB0; end
      5'd1:  begin addr_o = 8'h11; data_o = 8'h06; end
      5'd2:  begin addr_o = 8'h12; data_o = 8'hC8; end
      5'd3:  begin addr_o = 8'h44; data_o = {rate_sh[6:0], 1'b0}; end
      5'd4:  begin addr_o = 8'h17; data_o = 8'(in_div_i - 1'b1); end
      5'd5:  begin addr_o = 8'h18; data_o = fb_lo; end
      5'd6:  begin addr_o = 8'h18; data_o = 8'h80 | fb_hi; end
      5'd7:  begin addr_o = 8'h19; data_o = 8'h30; end
      5'd8:  begin addr_o = 8'h22; data_o = 8'h03; end
      5'd9:  begin addr_o = 8'h22; data_o = 8'h84; end
      5'd10: begin addr_o = 8'h20; data_o = 8'h4D; end
      5'd11: begin addr_o = 8'h21; data_o = 8'h39; end
      5'd12: begin addr_o = 8'h21; data_o = 8'hF4; end
      5'd13: begin addr_o = 8'h60; data_o = 8'h80 | bc_cnt(500, r); end
      5'd14: begin addr_o = 8'h61; data_o = 8'h80 | ui_cnt(40, r); end
      5'd15: begin addr_o = 8'h62; data_o = 8'h40 | bc_cnt(300, r); end
      5'd16: begin addr_o = 8'h63; data_o = 8'h80 | ui_cnt(100, r); end
      5'd17: begin addr_o = 8'h64; data_o = 8'h20 | bc_cnt(100, r); end
      5'd18: begin addr_o = 8'h65; data_o = 8'h20 | (bc_cnt(60, r) + 8'd7); end
      5'd19: begin addr_o = 8'h70; data_o = 8'h80 | bc_cnt(500, r); end
      5'd20: begin addr_o = 8'h71; data_o = 8'h80 | (ui_cnt(50, r) + 8'd5); end
      5'd21: begin addr_o = 8'h72; data_o = 8'h40 | (bc_cnt(140, r) + 8'd2); end
      5'd22: begin addr_o = 8'h73; data_o = 8'h80 | (ui_cnt(60, r) + 8'd8); end
      5'd23: begin addr_o = 8'h74; data_o = 8'h20 | bc_cnt(100, r); end
      default: begin addr_o = 8'h00; data_o = 8'h00; end
    endcase
  end
endmodule

// File: rtl/phy_us_timer.sv
module phy_us_timer #(
  parameter int LIMIT = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt <= '0;
    else if (tick_i && cnt != CNT_W'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign expired_o = (cnt == CNT_W'(LIMIT));
endmodule

// File: rtl/phy_pll_bringup.sv
module phy_pll_bringup
  import phy_bringup_pkg::*;
#(
  parameter int RATE_W     = 12,
  parameter int DIV_W      = 8,
  parameter int FB_W       = 10,
  parameter int TIMEOUT_US = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [RATE_W-1:0] lane_mbps_i,
  input  logic [DIV_W-1:0]  in_div_i,
  input  logic [FB_W-1:0]   fb_div_i,
  input  logic              us_tick_i,
  input  logic              pll_lock_i,
  input  logic              clk_stop_i,
  input  logic              wr_done_i,
  output logic              clr_pulse_o,
  output logic              wr_req_o,
  output logic [7:0]        wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              pll_force_o,
  output logic              clk_en_o,
  output logic              rst_n_o,
  output logic              shutdown_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              warn_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CFG - 1);

  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic [RATE_W-1:0] rate_q;
  logic [DIV_W-1:0]  in_div_q;
  logic [FB_W-1:0]   fb_q;
  logic [7:0]        tbl_addr, tbl_data;
  logic              tmr_clr, tmr_exp, ctl_on;

  phy_cfg_table #(.RATE_W(RATE_W), .DIV_W(DIV_W), .FB_W(FB_W)) u_table (
    .idx_i(idx), .rate_i(rate_q), .in_div_i(in_div_q), .fb_div_i(fb_q),
    .addr_o(tbl_addr), .data_o(tbl_data)
  );

  // Timer restarts on entry to each status wait
  assign tmr_clr = (state == ST_PWR) || (state == ST_LOCK && pll_lock_i);

  phy_us_timer #(.LIMIT(TIMEOUT_US)) u_timer (
    .clk(clk), .rst(rst), .clr_i(tmr_clr), .tick_i(us_tick_i), .expired_o(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; idx <= '0;
      rate_q <= '0; in_div_q <= '0; fb_q <= '0;
      clr_pulse_o <= 1'b0; wr_req_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
      ctl_on <= 1'b0; busy_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0; warn_o <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          rate_q <= lane_mbps_i; in_div_q <= in_div_i; fb_q <= fb_div_i;
          ctl_on <= 1'b0; busy_o <= 1'b1;
          done_o <= 1'b0; err_o <= 1'b0; warn_o <= 1'b0;
          state <= ST_CLR0;
        end
        ST_CLR0: begin clr_pulse_o <= 1'b0; state <= ST_CLR1; end
        ST_CLR1: begin clr_pulse_o <= 1'b1; state <= ST_CLR2; end
        ST_CLR2: begin clr_pulse_o <= 1'b0; idx <= '0; state <= ST_ISSUE; end
        ST_ISSUE: begin
          wr_req_o <= 1'b1; wr_addr_o <= tbl_addr; wr_data_o <= tbl_data;
          state <= ST_WAIT;
        end
        ST_WAIT: if (wr_done_i) begin
          wr_req_o <= 1'b0;
          if (idx == LAST_IDX) state <= ST_PWR;
          else begin idx <= idx + 1'b1; state <= ST_ISSUE; end
        end
        ST_PWR: begin ctl_on <= 1'b1; state <= ST_LOCK; end
        ST_LOCK: begin
          if (pll_lock_i) state <= ST_STOP;
          else if (tmr_exp) begin
            err_o <= 1'b1; done_o <= 1'b1; busy_o <= 1'b0; state <= ST_IDLE;
          end
        end
        ST_STOP: begin
          if (clk_stop_i) begin
            done_o <= 1'b1; busy_o <= 1'b0; state <= ST_IDLE;
          end else if (tmr_exp) begin
            warn_o <= 1'b1; done_o <= 1'b1; busy_o <= 1'b0; state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pll_force_o  = ctl_on;
  assign clk_en_o     = ctl_on;
  assign rst_n_o      = ctl_on;
  assign shutdown_n_o = ctl_on;
endmodule

// File: rtl/phy_pll_bringup_chk.sv
module phy_pll_bringup_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_req_o,
  input logic       wr_done_i,
  input logic [7:0] wr_addr_o,
  input logic [7:0] wr_data_o,
  input logic       pll_force_o,
  input logic       clk_en_o,
  input logic       rst_n_o,
  input logic       shutdown_n_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       warn_o
);
  assert_req_held_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_req_o && !wr_done_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_ctl_together_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones({pll_force_o, clk_en_o, rst_n_o, shutdown_n_o}) == 0) ||
    ($countones({pll_force_o, clk_en_o, rst_n_o, shutdown_n_o}) == 4));

  assert_ctl_off_in_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    wr_req_o |-> !rst_n_o);

  assert_err_ends_run_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);

  assert_warn_not_err_R8: assert property (@(posedge clk) disable iff (rst)
    warn_o |-> !err_o);

  assert_busy_done_excl_R12: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !done_o);
endmodule

bind phy_pll_bringup phy_pll_bringup_chk u_chk (.*);

// File: tb/phy_pll_bringup_tb.sv
module phy_pll_bringup_tb_top;
  localparam int LIM = 10000;
  logic clk = 0, rst = 1;
  logic start = 0, tick = 0, lock = 0, stopst = 0, wdone = 0;
  logic [11:0] rate = 0;
  logic [7:0]  indiv = 0;
  logic [9:0]  fb = 0;
  logic clr, wreq, pf, ce, rn, sn, busy, done, err, warn;
  logic [7:0] waddr, wdata;

  always #4 clk = ~clk;

  phy_pll_bringup #(.TIMEOUT_US(LIM)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .lane_mbps_i(rate), .in_div_i(indiv),
    .fb_div_i(fb), .us_tick_i(tick), .pll_lock_i(lock), .clk_stop_i(stopst),
    .wr_done_i(wdone), .clr_pulse_o(clr), .wr_req_o(wreq), .wr_addr_o(waddr),
    .wr_data_o(wdata), .pll_force_o(pf), .clk_en_o(ce), .rst_n_o(rn),
    .shutdown_n_o(sn), .busy_o(busy), .done_o(done), .err_o(err), .warn_o(warn)
  );

  int checks = 0, errors = 0, cyc = 0, tick_div = 1;
  logic [15:0] expq[$];
  int nwr = 0, clr_cnt = 0, lat = 0;
  logic pend = 0, clr_prev = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ui(int ns, int r); return ((ns * r + 999) / 1000) % 256; endfunction
  function automatic int bc(int ns, int r); return ((ns * r + 7999) / 8000) % 256; endfunction

  task automatic push(int a, int d); expq.push_back({8'(a), 8'(d)}); endtask

  task automatic build(int r, int idv, int f);
    push(8'h10, 8'hB0); push(8'h11, 8'h06); push(8'h12, 8'hC8);
    push(8'h44, ((r / 16) % 128) * 2);
    push(8'h17, (idv - 1) & 255);
    push(8'h18, f & 31); push(8'h18, 8'h80 | ((f >> 5) & 31));
    push(8'h19, 8'h30); push(8'h22, 8'h03); push(8'h22, 8'h84);
    push(8'h20, 8'h4D); push(8'h21, 8'h39); push(8'h21, 8'hF4);
    push(8'h60, 8'h80 | bc(500, r)); push(8'h61, 8'h80 | ui(40, r));
    push(8'h62, 8'h40 | bc(300, r)); push(8'h63, 8'h80 | ui(100, r));
    push(8'h64, 8'h20 | bc(100, r)); push(8'h65, 8'h20 | ((bc(60, r) + 7) % 256));
    push(8'h70, 8'h80 | bc(500, r)); push(8'h71, 8'h80 | ((ui(50, r) + 5) % 256));
    push(8'h72, 8'h40 | ((bc(140, r) + 2) % 256)); push(8'h73, 8'h80 | ((ui(60, r) + 8) % 256));
    push(8'h74, 8'h20 | bc(100, r));
  endtask

  // Tick generator and watchdog
  always @(negedge clk) begin
    cyc++;
    tick = (tick_div == 1) ? 1'b1 : ((cyc % tick_div) == 0);
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Bridge model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (clr && !clr_prev) clr_cnt++;
      if (clr_prev) chk(!clr, "R1 clear width", clr, 0);
      clr_prev = clr;
      if (wdone) wdone = 0;
      else if (wreq && !pend) begin
        logic [15:0] e;
        pend = 1; lat = nwr % 4;
        if (nwr == 0) begin
          chk(clr_cnt == 1, "R1 clear pulse count", clr_cnt, 1);
          chk(!clr, "R1 clear low at first write", clr, 0);
        end
        chk({pf, ce, rn, sn} == 4'h0, "R6 ctl low during config", {pf, ce, rn, sn}, 0);
        if (expq.size() == 0) chk(0, "R2 unexpected write", waddr, 0);
        else begin
          e = expq.pop_front();
          chk(waddr == e[15:8], "R2 address order", waddr, e[15:8]);
          chk(wdata == e[7:0], (nwr >= 13) ? "R4 timing data" : "R3 config data", wdata, e[7:0]);
        end
        nwr++;
      end else if (pend) begin
        chk(wreq, "R5 request held", wreq, 1);
        if (lat == 0) begin wdone = 1; pend = 0; end
        else lat--;
      end
    end
  end

  // One run: lock_dly / stop_dly of -1 means never
  task automatic run(int r, int idv, int f, int lock_dly, int stop_dly, bit mid, int tdiv);
    int n;
    tick_div = tdiv; nwr = 0; clr_cnt = 0;
    build(r, idv, f);
    @(negedge clk); rate = 12'(r); indiv = 8'(idv); fb = 10'(f); start = 1;
    @(negedge clk); start = 0;
    chk(busy && !done, "R12 busy after start", {busy, done}, 2);
    n = 0;
    while (!rn && n < 2000) begin
      @(negedge clk); n++;
      if (mid && n == 30) begin start = 1; rate = 12'd3000; indiv = 8'd99; fb = 10'h3FF; end
      if (mid && n == 31) start = 0;
    end
    chk(nwr == 24 && expq.size() == 0, "R6 ctl rise after last write", nwr, 24);
    chk({pf, ce, rn, sn} == 4'hF, "R6 all ctl together", {pf, ce, rn, sn}, 15);
    n = 0;
    if (lock_dly >= 0) begin
      repeat (lock_dly) @(negedge clk);
      lock = 1;
      if (stop_dly >= 0) begin
        repeat (stop_dly) @(negedge clk);
        stopst = 1;
        repeat (3) @(negedge clk);
        chk(done && !err && !warn && !busy, "R9 clean finish", {done, err, warn, busy}, 8);
        chk(rn && pf, "R9 ctl stay high", {pf, rn}, 3);
      end else begin
        while (!done && n < 3 * LIM * tdiv) begin @(negedge clk); n++; end
        chk(n >= LIM * tdiv - 1 && n <= LIM * tdiv + tdiv + 3, "R8 stop timeout delay", n, LIM * tdiv);
        chk(warn && !err && done, "R8 warning only", {warn, err, done}, 5);
      end
    end else begin
      while (!done && n < 3 * LIM * tdiv) begin @(negedge clk); n++; end
      chk(n >= LIM * tdiv && n <= LIM * tdiv + tdiv + 3, "R7 lock timeout delay", n, LIM * tdiv);
      chk(err && done && !warn, "R7 fatal error", {err, done, warn}, 6);
    end
    chk(!busy, "R12 busy cleared", busy, 0);
    if (mid) begin
      repeat (20) @(negedge clk);
      chk(!wreq && nwr == 24 && done, "R10 mid-run start ignored", nwr, 24);
    end
    lock = 0; stopst = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({clr, wreq, pf, ce, rn, sn, busy, done, err, warn} == 10'h0, "R11 reset state",
        {clr, wreq, pf, ce, rn, sn, busy, done, err, warn}, 0);
    chk(waddr == 0 && wdata == 0, "R11 reset bus", {waddr, wdata}, 0);
    run(200, 3, 10'h2A5, 40, 15, 0, 1);
    run(1000, 1, 10'h15A, 5, -1, 1, 1);
    run(80, 0, 10'h3E1, -1, -1, 0, 2);
    run(1500, 7, 10'h01F, 0, 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule